// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence for a four-beat burst in a synchronous memory. An address strobe captures a starting address. After that, each clock edge with the advance input active moves the burst one beat further. Only the two lowest address bits change; the upper bits keep the loaded value.

A static mode input selects the beat ordering. In linear ordering the low bits count upward modulo four from the start offset. In interleaved ordering the low bits are the start offset XORed with the number of beats taken.

The block presents the current address and the beat position, which is the number of advances since the last load, modulo four. It does not contain the memory array, the data path, the write control or the chip-enable decode.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous reset is high, a clock edge sets addr_out to 0 and beat_pos to 0.
- R2: A clock edge with strobe_proc_n low loads addr_in. From the next cycle, addr_out equals addr_in and beat_pos is 0 in either mode.
- R3: A clock edge with strobe_ctrl_n low loads addr_in in the same way as R2. The load also takes place when both strobes are low.
- R4: Linear ordering (mode_interleave = 0). With both strobes high, each edge with adv_n low adds 1 to beat_pos modulo 4, and addr_out[1:0] becomes (start + beat_pos) mod 4. Example for start 1: 1, 2, 3, 0.
- R5: Interleaved ordering (mode_interleave = 1). addr_out[1:0] equals start XOR beat_pos. Example for start 1: 1, 0, 3, 2.
- R6: An edge with both strobes high and adv_n high changes neither addr_out nor beat_pos.
- R7: Advances never change addr_out[ADDR_W-1:2]. No carry passes out of bit 1.
- R8: The fourth advance after a load returns beat_pos to 0 and addr_out to the loaded start address. Further advances repeat the same four-beat cycle.
- R9: When a strobe and adv_n are both low on the same edge, the load wins: the new address is taken and beat_pos is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_proc_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_interleave | input | 1 | 0 selects linear ordering, 1 selects interleaved ordering |
| addr_in | input | ADDR_W | Starting address, captured by a strobe |
| addr_out | output | ADDR_W | Current burst address |
| beat_pos | output | 2 | Advances since the last load, modulo 4 |

## Verification
Loading and advancing can be requested on the same edge. The bench provokes this collision in the middle of a running burst: a strobe and adv_n are held low together, with a new address that differs in both the upper and the low bits. Loading the new address with beat_pos at 0 counts as correct. If the design instead steps the old burst or offsets the new address by one beat, the bench reports it. The same case is repeated with both strobes low at once and in both orderings.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } act_e;

    typedef struct packed {
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
    } lo_state_t;

    function automatic logic [BEAT_W-1:0] linear_offset(
        input logic [BEAT_W-1:0] s,
        input logic [BEAT_W-1:0] b
    );
        return s + b;
    endfunction

    function automatic logic [BEAT_W-1:0] interleave_offset(
        input logic [BEAT_W-1:0] s,
        input logic [BEAT_W-1:0] b
    );
        return s ^ b;
    endfunction

endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl
    import burst_pkg::*;
(
    input  logic strobe_proc_n,
    input  logic strobe_ctrl_n,
    input  logic adv_n,
    output act_e act
);
    logic any_strobe;

    assign any_strobe = ~strobe_proc_n | ~strobe_ctrl_n;

    always_comb begin
        if (any_strobe)
            act = ACT_LOAD;
        else if (!adv_n)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16
)(
    input  logic                     clk,
    input  logic                     rst,
    input  act_e                     act,
    input  logic [ADDR_W-1:0]        addr_in,
    output logic [ADDR_W-BEAT_W-1:0] upper_q,
    output lo_state_t                lo_q
);
    localparam int UP_W = ADDR_W - BEAT_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q  <= '0;
            lo_q     <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    upper_q    <= addr_in[ADDR_W-1:BEAT_W];
                    lo_q.start <= addr_in[BEAT_W-1:0];
                    lo_q.beat  <= '0;
                end
                ACT_STEP: begin
                    lo_q.beat  <= lo_q.beat + 1'b1;
                end
                default: begin
                    upper_q  <= upper_q;
                    lo_q     <= lo_q;
                end
            endcase
        end
    end

    logic [UP_W-1:0] unused_width_probe;
    assign unused_width_probe = upper_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  order_e            order,
    input  lo_state_t         lo,
    output logic [BEAT_W-1:0] offset
);
    logic [BEAT_W-1:0] off_lin;
    logic [BEAT_W-1:0] off_ilv;

    assign off_lin = linear_offset(lo.start, lo.beat);
    assign off_ilv = interleave_offset(lo.start, lo.beat);

    always_comb begin
        unique case (order)
            ORD_INTERLEAVE: offset = off_ilv;
            default:        offset = off_lin;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_proc_n,
    input  logic              strobe_ctrl_n,
    input  logic              adv_n,
    input  logic              mode_interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat_pos
);
    localparam int UP_W = ADDR_W - BEAT_W;

    act_e              act;
    logic [UP_W-1:0]   upper_q;
    lo_state_t         lo_q;
    logic [BEAT_W-1:0] offset;
    order_e            order;

    assign order = order_e'(mode_interleave);

    burst_load_ctrl u_ctrl (
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctrl_n (strobe_ctrl_n),
        .adv_n         (adv_n),
        .act           (act)
    );

    burst_beat_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .addr_in (addr_in),
        .upper_q (upper_q),
        .lo_q    (lo_q)
    );

    burst_order_map u_map (
        .order  (order),
        .lo     (lo_q),
        .offset (offset)
    );

    assign addr_out = {upper_q, offset};
    assign beat_pos = lo_q.beat;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 16
)(
    input logic              clk,
    input logic              rst,
    input logic              strobe_proc_n,
    input logic              strobe_ctrl_n,
    input logic              adv_n,
    input logic              mode_interleave,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat_pos
);
    logic strobe_any;
    assign strobe_any = !strobe_proc_n || !strobe_ctrl_n;

    // R2 R3 R9
    load_takes_addr_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_any |=> (addr_out == $past(addr_in)) && (beat_pos == 2'd0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe_any && adv_n) |=> $stable(beat_pos) && $stable(addr_out[ADDR_W-1:2]));

    // R7
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_any |=> $stable(addr_out[ADDR_W-1:2]));

    // R8
    beat_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe_any && !adv_n) |=> beat_pos == $past(beat_pos) + 2'd1);

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe_any && !adv_n && !mode_interleave) |=>
        (mode_interleave || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

    // R5
    interleave_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe_any && !adv_n && mode_interleave) |=>
        (!mode_interleave ||
         (addr_out[1:0] ^ $past(addr_out[1:0])) == (beat_pos ^ $past(beat_pos))));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .strobe_proc_n   (strobe_proc_n),
    .strobe_ctrl_n   (strobe_ctrl_n),
    .adv_n           (adv_n),
    .mode_interleave (mode_interleave),
    .addr_in         (addr_in),
    .addr_out        (addr_out),
    .beat_pos        (beat_pos)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sp_n = 1'b1, sc_n = 1'b1, adv_n = 1'b1, mode = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic [1:0]        beat_pos;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [ADDR_W-3:0] m_up = '0;
    logic [1:0]        m_start = '0;
    logic [1:0]        m_beat = '0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .strobe_proc_n(sp_n), .strobe_ctrl_n(sc_n),
        .adv_n(adv_n), .mode_interleave(mode), .addr_in(addr_in),
        .addr_out(addr_out), .beat_pos(beat_pos)
    );

    function automatic logic [ADDR_W-1:0] model_addr();
        logic [1:0] off;
        off = mode ? (m_start ^ m_beat) : (m_start + m_beat);
        return {m_up, off};
    endfunction

    task automatic chk(input string tag);
        checks++;
        if (addr_out !== model_addr() || beat_pos !== m_beat) begin
            errors++;
            $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, addr_out, beat_pos, model_addr(), m_beat);
        end
    endtask

    task automatic step(input logic p, input logic c, input logic a,
                        input logic [ADDR_W-1:0] ad, input string tag);
        @(negedge clk);
        sp_n = p; sc_n = c; adv_n = a; addr_in = ad;
        @(posedge clk);
        #1;
        if (!p || !c) begin
            m_up = ad[ADDR_W-1:2]; m_start = ad[1:0]; m_beat = 2'd0;
        end else if (!a) begin
            m_beat = m_beat + 2'd1;
        end
        sp_n = 1'b1; sc_n = 1'b1; adv_n = 1'b1;
        chk(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; sp_n = 1'b0; addr_in = 16'hBEEF;
        @(posedge clk); #1;
        m_up = '0; m_start = '0; m_beat = '0;
        chk("R1 reset");
        @(negedge clk);
        rst = 1'b0; sp_n = 1'b1;
    endtask

    task automatic t_load_proc();
        mode = 1'b0;
        step(1'b0, 1'b1, 1'b1, 16'h1235, "R2 proc strobe load");
        mode = 1'b1;
        #1 chk("R2 load beat0 interleaved");
    endtask

    task automatic t_load_ctrl();
        mode = 1'b0;
        step(1'b1, 1'b0, 1'b1, 16'hA5A6, "R3 ctrl strobe load");
        step(1'b0, 1'b0, 1'b1, 16'h0F0F, "R3 both strobes load");
    endtask

    task automatic t_linear();
        mode = 1'b0;
        step(1'b0, 1'b1, 1'b1, 16'h4441, "R4 linear load start1");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, '0, "R4 linear advance");
    endtask

    task automatic t_interleave();
        mode = 1'b1;
        step(1'b1, 1'b0, 1'b1, 16'h7771, "R5 interleave load start1");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, '0, "R5 interleave advance");
        step(1'b1, 1'b0, 1'b1, 16'h7772, "R5 interleave load start2");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, '0, "R5 interleave advance s2");
    endtask

    task automatic t_hold();
        mode = 1'b0;
        step(1'b0, 1'b1, 1'b1, 16'h3332, "R6 load");
        step(1'b1, 1'b1, 1'b0, '0, "R6 advance");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 16'hFFFF, "R6 hold with noise on addr_in");
    endtask

    task automatic t_wrap();
        mode = 1'b0;
        step(1'b0, 1'b1, 1'b1, 16'hFFFF, "R7 load top address");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, '0, "R7 R8 linear no carry");
        checks++;
        if (addr_out !== 16'hFFFF || beat_pos !== 2'd0) begin
            errors++;
            $display("FAIL R8 wrap addr=%h beat=%0d expected addr=ffff beat=0", addr_out, beat_pos);
        end
        mode = 1'b1;
        step(1'b1, 1'b0, 1'b1, 16'h8002, "R8 load interleaved");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, '0, "R7 R8 interleaved wrap");
    endtask

    task automatic t_collide();
        mode = 1'b0;
        step(1'b0, 1'b1, 1'b1, 16'h1110, "R9 setup");
        step(1'b1, 1'b1, 1'b0, '0, "R9 setup advance");
        step(1'b0, 1'b1, 1'b0, 16'h2223, "R9 proc strobe beats advance");
        step(1'b1, 1'b1, 1'b0, '0, "R9 advance after collide");
        mode = 1'b1;
        step(1'b0, 1'b0, 1'b0, 16'h5551, "R9 both strobes with advance");
        step(1'b1, 1'b1, 1'b0, '0, "R9 interleave after collide");
    endtask

    initial begin
        t_reset();
        t_load_proc();
        t_load_ctrl();
        t_linear();
        t_interleave();
        t_hold();
        t_wrap();
        t_collide();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule